// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a multi-cycle processor core in which every instruction is spread over several clock cycles and shares one memory, one ALU and one register file across those cycles. It is a Moore machine: a small state register selects one of ten states, and the full set of datapath steering signals (write enables, multiplexer selects and an ALU operation class) is decoded from that state alone. The 6-bit opcode taken from the instruction register only influences which state comes next.

Every instruction starts with two common states, an instruction fetch and a decode/register read. From decode the sequencer branches into a private path for memory access, register-to-register arithmetic, conditional branch or jump, and each path ends by returning to fetch. A load needs five cycles, a store or an arithmetic instruction four, and a branch or a jump three. An opcode that the sequencer does not recognise is abandoned in decode and the machine fetches the next instruction without having asserted any write.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch state (state code 0) on the next clock edge, from any state, and holds it there while asserted.
- R2: The fetch state (0) drives mem_rd_o=1, instr_latch_o=1, pc_wr_o=1, alu_a_reg_o=0, alu_b_sel_o=01, alu_cls_o=00, pc_src_o=00 and all other controls 0, and is always followed by the decode state (code 1).
- R3: In decode (code 1, outputs alu_b_sel_o=11 and all others 0) the opcode picks the next state: 6'h23 (load) and 6'h2B (store) go to address calculation (code 2), 6'h00 (register arithmetic) to execute (code 6), 6'h04 (branch) to branch completion (code 8), 6'h02 (jump) to jump completion (code 9).
- R4: In address calculation (code 2, outputs alu_a_reg_o=1, alu_b_sel_o=10, alu_cls_o=00) a load opcode leads to memory read (code 3) and a store opcode to memory write (code 5).
- R5: Memory read (3) is followed by load write-back (4), execute (6) by arithmetic write-back (7), and states 4, 5, 7, 8 and 9 each return to fetch.
- R6: Counting from entry into fetch until the next fetch, a load takes 5 cycles, a store 4, register arithmetic 4, a branch 3 and a jump 3.
- R7: An unrecognised opcode in decode returns the machine to fetch with no write enable asserted in between; an opcode that is neither load nor store seen in address calculation also returns to fetch.
- R8: The control outputs depend only on the current state; changing the opcode within a cycle does not change them, and in states other than 1 and 2 the opcode does not change the next state.
- R9: Memory read (3) asserts mem_rd_o and addr_data_o; memory write (5) asserts mem_wr_o and addr_data_o; mem_rd_o and mem_wr_o are never both 1.
- R10: Load write-back (4) asserts reg_wr_o with wb_mem_o=1 and dst_rd_o=0; arithmetic write-back (7) asserts reg_wr_o with wb_mem_o=0 and dst_rd_o=1.
- R11: Execute (6) drives alu_a_reg_o=1, alu_b_sel_o=00, alu_cls_o=10 (function-field class) with no write enable.
- R12: Branch completion (8) drives alu_a_reg_o=1, alu_b_sel_o=00, alu_cls_o=01 (subtract), pc_wr_zero_o=1, pc_src_o=01; jump completion (9) drives pc_wr_o=1, pc_src_o=10 and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OPC_W | Opcode field of the held instruction |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_zero_o | output | 1 | Program counter write when the ALU result is zero |
| addr_data_o | output | 1 | Memory address from the ALU output register (0: program counter) |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| instr_latch_o | output | 1 | Instruction register load enable |
| wb_mem_o | output | 1 | Write-back data from memory data register (0: ALU output) |
| dst_rd_o | output | 1 | Destination register from the rd field (0: rt field) |
| reg_wr_o | output | 1 | Register file write enable |
| alu_a_reg_o | output | 1 | ALU first operand from register A (0: program counter) |
| alu_b_sel_o | output | 2 | ALU second operand: 00 reg B, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| alu_cls_o | output | 2 | ALU class: 00 add, 01 subtract, 10 by function field |
| pc_src_o | output | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump target |
| state_o | output | 4 | Current state code |

## Verification
A table walks each of the five recognised opcodes and two unrecognised ones from fetch back to fetch, checking the state code and the full control word every cycle; this tells apart a wrong dispatch (state path differs), a wrong cycle count (return to fetch early or late) and a wrong output decode (control word differs in one state). Directed tests change the opcode in the middle of execute to show that outputs and path ignore it, swap the opcode in address calculation to an unknown value to hit the abort path there, and apply reset in the middle of a load to show it wins over the sequence.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   localparam int ST_W = 4;

   typedef enum logic [ST_W-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_MRD    = 4'd3,
      ST_LDWB   = 4'd4,
      ST_MWR    = 4'd5,
      ST_EXEC   = 4'd6,
      ST_RWB    = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9
   } st_e;

   localparam int NUM_CLS = 5;

   typedef enum logic [2:0] {
      OC_NONE   = 3'd0,
      OC_LOAD   = 3'd1,
      OC_STORE  = 3'd2,
      OC_RTYPE  = 3'd3,
      OC_BRANCH = 3'd4,
      OC_JUMP   = 3'd5
   } opc_e;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_zero;
      logic       addr_data;
      logic       mem_rd;
      logic       mem_wr;
      logic       instr_latch;
      logic       wb_mem;
      logic       dst_rd;
      logic       reg_wr;
      logic       alu_a_reg;
      logic [1:0] alu_b_sel;
      logic [1:0] alu_cls;
      logic [1:0] pc_src;
   } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
   import mc_ctrl_pkg::*;
#(
   parameter int                OPC_W     = 6,
   parameter logic [OPC_W-1:0]  OP_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0]  OP_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0]  OP_RTYPE  = 6'h00,
   parameter logic [OPC_W-1:0]  OP_BRANCH = 6'h04,
   parameter logic [OPC_W-1:0]  OP_JUMP   = 6'h02
) (
   input  logic [OPC_W-1:0] opcode_i,
   output opc_e             cls_o
);
   localparam logic [NUM_CLS*OPC_W-1:0] OP_TAB =
      {OP_JUMP, OP_BRANCH, OP_RTYPE, OP_STORE, OP_LOAD};

   logic [NUM_CLS-1:0] hit;

   for (genvar k = 0; k < NUM_CLS; k++) begin : g_match
      for (genvar m = k + 1; m < NUM_CLS; m++) begin : g_uniq
         if (OP_TAB[k*OPC_W +: OPC_W] == OP_TAB[m*OPC_W +: OPC_W]) begin : g_dup
            $error("mc_op_classify: two instruction classes share one opcode");
         end
      end
      assign hit[k] = (opcode_i == OP_TAB[k*OPC_W +: OPC_W]);
   end

   always_comb begin
      cls_o = OC_NONE;
      for (int k = 0; k < NUM_CLS; k++) begin
         if (hit[k]) cls_o = opc_e'(k + 1);
      end
   end

   // R3: distinct opcodes can hit at most one class
   always_comb begin
      assert_unique_decode_R3: assert ($onehot0(hit));
   end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
   import mc_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  opc_e cls_i,
   output st_e  state_o
);
   st_e state_q, state_d;

   always_comb begin
      state_d = ST_FETCH;
      unique case (state_q)
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: begin
            unique case (cls_i)
               OC_LOAD, OC_STORE: state_d = ST_ADDR;
               OC_RTYPE:          state_d = ST_EXEC;
               OC_BRANCH:         state_d = ST_BRANCH;
               OC_JUMP:           state_d = ST_JUMP;
               default:           state_d = ST_FETCH;
            endcase
         end
         ST_ADDR: begin
            if (cls_i == OC_LOAD)       state_d = ST_MRD;
            else if (cls_i == OC_STORE) state_d = ST_MWR;
            else                        state_d = ST_FETCH;
         end
         ST_MRD:  state_d = ST_LDWB;
         ST_EXEC: state_d = ST_RWB;
         default: state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   assign state_o = state_q;

   assert_reset_fetch_R1: assert property (@(posedge clk)
      rst |=> state_q == ST_FETCH);

   assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_FETCH |=> state_q == ST_DECODE);

   assert_read_to_wb_R5: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_MRD |=> state_q == ST_LDWB);

   assert_exec_to_wb_R5: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_EXEC |=> state_q == ST_RWB);

   assert_tail_return_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q inside {ST_LDWB, ST_MWR, ST_RWB, ST_BRANCH, ST_JUMP})
      |=> state_q == ST_FETCH);

   assert_unknown_abort_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DECODE && cls_i == OC_NONE) |=> state_q == ST_FETCH);
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
   import mc_ctrl_pkg::*;
(
   input  st_e   state_i,
   output ctrl_t ctrl_o
);
   always_comb begin
      ctrl_o = '0;
      unique case (state_i)
         ST_FETCH: begin
            ctrl_o.mem_rd      = 1'b1;
            ctrl_o.instr_latch = 1'b1;
            ctrl_o.pc_wr       = 1'b1;
            ctrl_o.alu_b_sel   = 2'b01;
         end
         ST_DECODE: ctrl_o.alu_b_sel = 2'b11;
         ST_ADDR: begin
            ctrl_o.alu_a_reg = 1'b1;
            ctrl_o.alu_b_sel = 2'b10;
         end
         ST_MRD: begin
            ctrl_o.mem_rd    = 1'b1;
            ctrl_o.addr_data = 1'b1;
         end
         ST_LDWB: begin
            ctrl_o.reg_wr = 1'b1;
            ctrl_o.wb_mem = 1'b1;
         end
         ST_MWR: begin
            ctrl_o.mem_wr    = 1'b1;
            ctrl_o.addr_data = 1'b1;
         end
         ST_EXEC: begin
            ctrl_o.alu_a_reg = 1'b1;
            ctrl_o.alu_cls   = 2'b10;
         end
         ST_RWB: begin
            ctrl_o.reg_wr = 1'b1;
            ctrl_o.dst_rd = 1'b1;
         end
         ST_BRANCH: begin
            ctrl_o.alu_a_reg  = 1'b1;
            ctrl_o.alu_cls    = 2'b01;
            ctrl_o.pc_wr_zero = 1'b1;
            ctrl_o.pc_src     = 2'b01;
         end
         ST_JUMP: begin
            ctrl_o.pc_wr  = 1'b1;
            ctrl_o.pc_src = 2'b10;
         end
         default: ctrl_o = '0;
      endcase
   end

   always_comb begin
      // R9: memory never read and written in one cycle
      assert_mem_excl_R9: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr));
      // R7: decode, where an unknown opcode is dropped, writes nothing
      assert_decode_quiet_R7: assert (state_i != ST_DECODE ||
         !(ctrl_o.pc_wr || ctrl_o.pc_wr_zero || ctrl_o.mem_wr ||
           ctrl_o.reg_wr || ctrl_o.instr_latch));
   end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mc_ctrl_pkg::*;
#(
   parameter int                OPC_W     = 6,
   parameter logic [OPC_W-1:0]  OP_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0]  OP_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0]  OP_RTYPE  = 6'h00,
   parameter logic [OPC_W-1:0]  OP_BRANCH = 6'h04,
   parameter logic [OPC_W-1:0]  OP_JUMP   = 6'h02
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode_i,
   output logic             pc_wr_o,
   output logic             pc_wr_zero_o,
   output logic             addr_data_o,
   output logic             mem_rd_o,
   output logic             mem_wr_o,
   output logic             instr_latch_o,
   output logic             wb_mem_o,
   output logic             dst_rd_o,
   output logic             reg_wr_o,
   output logic             alu_a_reg_o,
   output logic [1:0]       alu_b_sel_o,
   output logic [1:0]       alu_cls_o,
   output logic [1:0]       pc_src_o,
   output logic [ST_W-1:0]  state_o
);
   if (OPC_W < 1) begin : g_bad_width
      $error("mc_ctrl_fsm: OPC_W must be at least 1");
   end

   opc_e  cls;
   st_e   state;
   ctrl_t ctrl;

   mc_op_classify #(
      .OPC_W(OPC_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
      .OP_RTYPE(OP_RTYPE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
   ) u_cls (
      .opcode_i (opcode_i),
      .cls_o    (cls)
   );

   mc_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .cls_i   (cls),
      .state_o (state)
   );

   mc_ctrl_decode u_dec (
      .state_i (state),
      .ctrl_o  (ctrl)
   );

   assign pc_wr_o       = ctrl.pc_wr;
   assign pc_wr_zero_o  = ctrl.pc_wr_zero;
   assign addr_data_o   = ctrl.addr_data;
   assign mem_rd_o      = ctrl.mem_rd;
   assign mem_wr_o      = ctrl.mem_wr;
   assign instr_latch_o = ctrl.instr_latch;
   assign wb_mem_o      = ctrl.wb_mem;
   assign dst_rd_o      = ctrl.dst_rd;
   assign reg_wr_o      = ctrl.reg_wr;
   assign alu_a_reg_o   = ctrl.alu_a_reg;
   assign alu_b_sel_o   = ctrl.alu_b_sel;
   assign alu_cls_o     = ctrl.alu_cls;
   assign pc_src_o      = ctrl.pc_src;
   assign state_o       = state;

   // R8: a Moore output only moves at a clock edge
   assert_moore_stable_R8: assert property (@(posedge clk) disable iff (rst)
      $stable(state_o) |-> $stable({pc_wr_o, pc_wr_zero_o, mem_rd_o, mem_wr_o,
                                     reg_wr_o, alu_cls_o, pc_src_o}));
endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'h00;
   logic pc_wr, pc_wr_zero, addr_data, mem_rd, mem_wr, instr_latch;
   logic wb_mem, dst_rd, reg_wr, alu_a_reg;
   logic [1:0] alu_b_sel, alu_cls, pc_src;
   logic [3:0] state;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   mc_ctrl_fsm dut (
      .clk(clk), .rst(rst), .opcode_i(opcode),
      .pc_wr_o(pc_wr), .pc_wr_zero_o(pc_wr_zero), .addr_data_o(addr_data),
      .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .instr_latch_o(instr_latch),
      .wb_mem_o(wb_mem), .dst_rd_o(dst_rd), .reg_wr_o(reg_wr),
      .alu_a_reg_o(alu_a_reg), .alu_b_sel_o(alu_b_sel), .alu_cls_o(alu_cls),
      .pc_src_o(pc_src), .state_o(state)
   );

   // control word order: pc_wr pc_wr_zero addr_data mem_rd mem_wr instr_latch
   //                     wb_mem dst_rd reg_wr alu_a_reg alu_b(2) alu_cls(2) pc_src(2)
   function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
      case (s)
         4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00}; // R2
         4'd1: return {10'b0, 2'b11, 2'b00, 2'b00};                                      // R3
         4'd2: return {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};                                 // R4
         4'd3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,6'b0};          // R9
         4'd4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,6'b0};          // R10
         4'd5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,6'b0};          // R9
         4'd6: return {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};                                 // R11
         4'd7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,6'b0};          // R10
         4'd8: return {1'b0,1'b1,7'b0,1'b1,2'b00,2'b01,2'b01};                           // R12
         4'd9: return {1'b1,9'b0,2'b00,2'b00,2'b10};                                     // R12
         default: return 16'h0;
      endcase
   endfunction

   function automatic logic [15:0] act_ctrl();
      return {pc_wr, pc_wr_zero, addr_data, mem_rd, mem_wr, instr_latch,
              wb_mem, dst_rd, reg_wr, alu_a_reg, alu_b_sel, alu_cls, pc_src};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // entry: opcode, cycles fetch-to-fetch, state path (first state in top nibble)
   localparam int NV = 7;
   localparam logic [28:0] VEC [NV] = '{
      {6'h23, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},  // load
      {6'h2B, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},  // store
      {6'h00, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},  // register arithmetic
      {6'h04, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},  // branch
      {6'h02, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},  // jump
      {6'h3F, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},  // unknown
      {6'h08, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0}   // unknown
   };

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      logic        wrote;
      repeat (3) step();
      chk("R1 reset state", state, 4'd0);
      chk("R1 reset outputs", act_ctrl(), exp_ctrl(4'd0));
      rst = 1'b0;

      for (int v = 0; v < NV; v++) begin
         logic [5:0] op;
         int         cyc;
         op  = VEC[v][28:23];
         cyc = int'(VEC[v][22:20]);
         opcode = op;
         wrote = 1'b0;
         for (int i = 0; i < cyc; i++) begin
            logic [3:0] es;
            es = VEC[v][19 - 4*i -: 4];
            chk("R3 R4 R5 state path", state, es);
            chk("R2 R9 R10 R11 R12 control word", act_ctrl(), exp_ctrl(es));
            if (i > 0 && (pc_wr || pc_wr_zero || mem_wr || reg_wr || instr_latch)) wrote = 1'b1;
            step();
         end
         chk("R6 cycle count back to fetch", state, 4'd0);
         if (v >= 5) chk("R7 no write on unknown opcode", wrote, 1'b0);
      end

      // R8: opcode change inside execute changes neither outputs nor path
      opcode = 6'h00;
      step(); step();
      chk("R8 in execute", state, 4'd6);
      held = act_ctrl();
      opcode = 6'h23;
      #1;
      chk("R8 outputs ignore opcode", act_ctrl(), held);
      step();
      chk("R8 next state ignores opcode", state, 4'd7);
      step();
      chk("R5 write-back returns to fetch", state, 4'd0);

      // R7: unknown opcode in address calculation aborts to fetch
      opcode = 6'h23;
      step(); step();
      chk("R7 in address calc", state, 4'd2);
      opcode = 6'h3F;
      step();
      chk("R7 abort from address calc", state, 4'd0);
      chk("R7 fetch outputs after abort", act_ctrl(), exp_ctrl(4'd0));

      // R1: reset in the middle of a load
      opcode = 6'h23;
      step(); step(); step();
      chk("R9 in memory read", state, 4'd3);
      rst = 1'b1;
      step();
      chk("R1 mid-sequence reset", state, 4'd0);
      step();
      chk("R1 held in reset", state, 4'd0);
      rst = 1'b0;
      step();
      chk("R2 decode after fetch", state, 4'd1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule